// File: doc/BRIEF.md
# Buffered Serial Transmitter with Programmable Interrupt Timing

This block is an asynchronous serial transmitter with a one-character holding register in front of its shift register. Software writes a character with a strobe. The character waits in the holding register until the next bit-rate tick, then moves into the shifter and goes out on the line. The line rests high. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts from one tick to the next.

The block's main job is to decide when the transmit-interrupt flag is set. Three configuration inputs control this: a buffering-mode bit, a bit that requests one extra interrupt after the last character, and a bit that chooses whether the flag is raised at the start or at the end of the stop bit.

With two-stage buffering on, a write into an empty transmitter raises the flag at once. A character that is still waiting raises it at the stop point of the frame ahead of it. A frame that ends with another character held starts the next frame with no idle bit. A write that cannot be accepted is dropped, and a sticky collision flag records it. Software clears both flags with pulse inputs.

Top module: `dbuf_uart_tx`

## Requirements
- R1: The line is high when idle. A frame is one low start bit, DATA_W data bits least significant bit first, then one high stop bit. Each bit starts on the clock after a bitTick cycle and lasts until the clock after the next bitTick. A waiting character begins its start bit on the clock after the first bitTick that follows the write.
- R2: When dblBufEn is 0, a write is accepted only if the holding register and the shifter are both empty. The character's single interrupt comes at its own stop point. After the stop bit the line stays high until a new write has been made and a tick has followed it.
- R3: When irqAtStopEnd is 0, a stop-point interrupt is set on the clock that follows the tick at which the last data bit ends.
- R4: When irqAtStopEnd is 1, a stop-point interrupt is set on the clock that follows the tick at which the stop bit ends.
- R5: When dblBufEn is 1 and a write arrives while the holding register and the shifter are both empty, txIrq is high on the next clock.
- R6: When dblBufEn is 1 and a character is held as the stop bit ends, its start bit begins on that same clock, with no idle bit between the frames.
- R7: When extraIrqSel is 0, exactly one interrupt is set for each accepted write. In two-stage mode a character that did not get the immediate interrupt gets it at the stop point of the first frame that reaches its stop point while the character is waiting.
- R8: When dblBufEn and extraIrqSel are both 1, one further interrupt is set at a stop point where no character interrupt is owed and the holding register is empty.
- R9: When dblBufEn is 0, extraIrqSel has no effect on when interrupts occur or how many occur.
- R10: A write that is not accepted leaves the held and transmitted data unchanged. It sets wrCollision on the next clock, and wrCollision stays set until a colClr pulse.
- R11: txIrq stays set until irqClr is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R12: Reset drives txLine high and clears txIrq and wrCollision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | Bit-rate tick, one cycle wide |
| wrEn | input | 1 | Write strobe for a character |
| wrData | input | DATA_W | Character to send |
| dblBufEn | input | 1 | 1 selects two-stage buffering |
| extraIrqSel | input | 1 | 1 requests a final interrupt after the last character (two-stage mode only) |
| irqAtStopEnd | input | 1 | 0 selects the start of the stop bit as the interrupt point, 1 selects its end |
| irqClr | input | 1 | Clears txIrq |
| colClr | input | 1 | Clears wrCollision |
| txLine | output | 1 | Serial output line |
| txIrq | output | 1 | Sticky transmit-interrupt flag |
| wrCollision | output | 1 | Sticky flag for a dropped write |

## Verification
The bench targets the places where interrupts are easy to miscount.

- **Immediate interrupt.** A design that forgets the immediate interrupt for a first character, or that also signals that character again at its stop bit, is caught by comparing the number of flag events with the number of writes.
- **Back-to-back frames.** A design that inserts an idle bit between two queued frames shows a high line where the bench expects a start bit.
- **Interrupt point.** A design that ignores the start-or-end selection is one bit-time early or late.
- **Extra interrupt.** A design that honours the extra-interrupt request in single-buffer mode reports one event too many.
- **Dropped writes.** A write made while the buffer is full must corrupt nothing that goes out on the line, and must leave the collision flag set.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

  // Strobes from the control path to the datapath, one cycle wide
  typedef struct packed {
    logic holdWr;  // capture wrData into the holding register
    logic shLoad;  // move held data into the shifter, drive start bit
    logic shAdv;   // drive next data bit, shift right
    logic shStop;  // drive the line high (stop bit or idle)
  } txStrobe_t;

endpackage

// File: rtl/dbuf_uart_tx_ctrl.sv
module dbuf_uart_tx_ctrl
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  bitTick,
  input  logic                                  wrEn,
  input  logic                                  dblBufEn,
  input  logic                                  extraIrqSel,
  input  logic                                  irqAtStopEnd,
  input  logic                                  irqClr,
  input  logic                                  colClr,
  output txStrobe_t                             strb,
  output logic                                  holdFull,
  output logic                                  shBusy,
  output logic [$clog2(DATA_W+2)-1:0]           bitIdx,
  output logic                                  txIrq,
  output logic                                  wrCollision
);

  localparam int FRAME_LEN = DATA_W + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);
  localparam int OWED_W    = 2;

  logic [OWED_W-1:0] owedCnt, owedNext;
  logic extraOn, accept, immIrq;
  logic atLastData, atStop, stopStartEv, stopEndEv, stopPoint;
  logic owedIrq, extraIrq, loadNow;

  always_comb begin
    extraOn     = dblBufEn & extraIrqSel;
    accept      = wrEn & ~holdFull & (dblBufEn | ~shBusy);
    immIrq      = accept & dblBufEn & ~shBusy;
    atLastData  = shBusy & (bitIdx == LAST_IDX);
    atStop      = shBusy & (bitIdx == STOP_IDX);
    stopStartEv = bitTick & atLastData;
    stopEndEv   = bitTick & atStop;
    stopPoint   = irqAtStopEnd ? stopEndEv : stopStartEv;
    owedIrq     = stopPoint & (owedCnt != '0);
    extraIrq    = stopPoint & (owedCnt == '0) & extraOn & ~holdFull;
    loadNow     = bitTick & holdFull & (~shBusy | atStop);

    owedNext = owedCnt;
    if (accept & ~immIrq) owedNext = owedNext + OWED_W'(1);
    if (owedIrq)          owedNext = owedNext - OWED_W'(1);

    strb.holdWr = accept;
    strb.shLoad = loadNow;
    strb.shAdv  = bitTick & shBusy & (bitIdx < LAST_IDX);
    strb.shStop = stopStartEv | stopEndEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shBusy      <= 1'b0;
      bitIdx      <= '0;
      holdFull    <= 1'b0;
      owedCnt     <= '0;
      txIrq       <= 1'b0;
      wrCollision <= 1'b0;
    end else begin
      if (loadNow) begin
        shBusy   <= 1'b1;
        bitIdx   <= '0;
        holdFull <= 1'b0;
      end else begin
        if (stopEndEv) begin
          shBusy <= 1'b0;
          bitIdx <= '0;
        end else if (bitTick & shBusy) begin
          bitIdx <= bitIdx + IDX_W'(1);
        end
        if (accept) holdFull <= 1'b1;
      end
      owedCnt     <= owedNext;
      txIrq       <= (txIrq & ~irqClr) | immIrq | owedIrq | extraIrq;
      wrCollision <= (wrCollision & ~colClr) | (wrEn & ~accept);
    end
  end

endmodule

// File: rtl/dbuf_uart_tx_dp.sv
module dbuf_uart_tx_dp
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strb,
  output logic [DATA_W-1:0] holdData,
  output logic              txLine
);

  logic [DATA_W-1:0] shiftData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData  <= '0;
      shiftData <= '0;
      txLine    <= 1'b1;
    end else begin
      if (strb.holdWr) holdData <= wrData;
      if (strb.shLoad) begin
        shiftData <= holdData;
        txLine    <= 1'b0;
      end else if (strb.shAdv) begin
        txLine    <= shiftData[0];
        shiftData <= shiftData >> 1;
      end else if (strb.shStop) begin
        txLine    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dblBufEn,
  input  logic              extraIrqSel,
  input  logic              irqAtStopEnd,
  input  logic              irqClr,
  input  logic              colClr,
  output logic              txLine,
  output logic              txIrq,
  output logic              wrCollision
);

  localparam int IDX_W = $clog2(DATA_W + 2);

  txStrobe_t         strb;
  logic              holdFull;
  logic              shBusy;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] holdData;

  dbuf_uart_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn),
    .dblBufEn(dblBufEn), .extraIrqSel(extraIrqSel), .irqAtStopEnd(irqAtStopEnd),
    .irqClr(irqClr), .colClr(colClr), .strb(strb), .holdFull(holdFull),
    .shBusy(shBusy), .bitIdx(bitIdx), .txIrq(txIrq), .wrCollision(wrCollision)
  );

  dbuf_uart_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb),
    .holdData(holdData), .txLine(txLine)
  );

endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic                          dblBufEn,
  input logic                          irqClr,
  input logic                          txLine,
  input logic                          txIrq,
  input logic                          wrCollision,
  input logic                          holdFull,
  input logic                          shBusy,
  input logic [$clog2(DATA_W+2)-1:0]   bitIdx,
  input logic [DATA_W-1:0]             holdData
);

  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (shBusy && bitIdx == '0) |-> !txLine);

  assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (shBusy && bitIdx == STOP_IDX) |-> txLine);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !shBusy |-> txLine);

  assert_single_busy_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!dblBufEn && wrEn && shBusy) |=> wrCollision);

  assert_immediate_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dblBufEn && wrEn && !holdFull && !shBusy) |=> txIrq);

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && holdFull) |=> (wrCollision && $stable(holdData)));

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !irqClr) |=> txIrq);

endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .dblBufEn(dblBufEn), .irqClr(irqClr),
  .txLine(txLine), .txIrq(txIrq), .wrCollision(wrCollision),
  .holdFull(holdFull), .shBusy(shBusy), .bitIdx(bitIdx), .holdData(holdData)
);

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
module dbuf_uart_tx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, wrEn = 1'b0, dblBufEn = 1'b0, extraIrqSel = 1'b0;
  logic irqAtStopEnd = 1'b0, irqClr = 1'b0, colClr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic txLine, txIrq, wrCollision;

  int total = 0, bad = 0, cyc = 0, irqSeen = 0;
  bit autoClr = 1'b0, done = 1'b0;
  logic lastIrq = 1'b0, lastCol = 1'b0;

  always #2 clk = ~clk;

  dbuf_uart_tx u_dbuf_uart_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn), .wrData(wrData),
    .dblBufEn(dblBufEn), .extraIrqSel(extraIrqSel), .irqAtStopEnd(irqAtStopEnd),
    .irqClr(irqClr), .colClr(colClr), .txLine(txLine), .txIrq(txIrq),
    .wrCollision(wrCollision)
  );

  // Reference model written from the requirements
  logic       mBusy, mHf, mLine, mIrq, mCol;
  logic [3:0] mPos;
  logic [9:0] mFrame;
  logic [7:0] mHold;
  int         mOwed;

  always @(posedge clk or negedge rstN) begin : refModel
    logic acc, imm, ptStart, ptEnd, pt, setIrq;
    int owedN;
    if (!rstN) begin
      mBusy <= 0; mHf <= 0; mLine <= 1; mIrq <= 0; mCol <= 0;
      mPos <= 0; mFrame <= '0; mHold <= '0; mOwed <= 0;
    end else begin
      acc     = wrEn && !mHf && (dblBufEn || !mBusy);
      imm     = acc && dblBufEn && !mBusy;
      ptStart = bitTick && mBusy && mPos == 4'd8;
      ptEnd   = bitTick && mBusy && mPos == 4'd9;
      pt      = irqAtStopEnd ? ptEnd : ptStart;
      setIrq  = imm;
      owedN   = mOwed + ((acc && !imm) ? 1 : 0);
      if (pt) begin
        if (mOwed != 0) begin setIrq = 1; owedN = owedN - 1; end
        else if (dblBufEn && extraIrqSel && !mHf) setIrq = 1;
      end
      mOwed <= owedN;
      mIrq  <= (mIrq && !irqClr) || setIrq;
      mCol  <= (mCol && !colClr) || (wrEn && !acc);
      if (acc) begin mHold <= wrData; mHf <= 1; end
      if (bitTick && mHf && (!mBusy || mPos == 4'd9)) begin
        mFrame <= {1'b1, mHold, 1'b0};
        mPos <= 0; mBusy <= 1; mLine <= 0; mHf <= 0;
      end else if (bitTick && mBusy) begin
        if (mPos == 4'd9) begin mBusy <= 0; mLine <= 1; end
        else begin mPos <= mPos + 4'd1; mLine <= mFrame[mPos + 4'd1]; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic cc, input string tag);
    @(negedge clk);
    chk(txLine == mLine, tag, "txLine", int'(txLine), int'(mLine));
    chk(txIrq == mIrq, tag, "txIrq", int'(txIrq), int'(mIrq));
    chk(wrCollision == mCol, tag, "wrCollision", int'(wrCollision), int'(mCol));
    lastIrq = txIrq;
    lastCol = wrCollision;
    if (txIrq) irqSeen++;
    bitTick = (cyc % 4 == 3);
    cyc++;
    wrEn = w; wrData = d; colClr = cc;
    irqClr = autoClr ? txIrq : ($urandom % 8 == 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, tag);
  endtask

  task automatic setCfg(input logic db, input logic ex, input logic en);
    dblBufEn = db; extraIrqSel = ex; irqAtStopEnd = en;
  endtask

  // Two-stage scenario: A immediate, B waits behind A, C waits behind B
  task automatic dblRun(input logic ex, input logic en, input int expIrq, input string tag);
    setCfg(1, ex, en);
    irqSeen = 0;
    step(1, 8'h3C, 0, tag);
    step(0, 8'h00, 0, tag);
    chk(lastIrq == 1'b1, "R5", "immediate txIrq", int'(lastIrq), 1);
    idle(6, tag);
    step(1, 8'hC3, 0, tag);
    idle(47, tag);
    step(1, 8'h81, 0, tag);
    idle(160, tag);
    chk(irqSeen == expIrq, tag, "irq count", irqSeen, expIrq);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : mainSeq
    int seed;
    seed = $urandom(32'h1EAF);
    // R12 reset state
    repeat (3) @(negedge clk);
    chk(txLine == 1'b1, "R12", "reset txLine", int'(txLine), 1);
    chk(txIrq == 1'b0, "R12", "reset txIrq", int'(txIrq), 0);
    chk(wrCollision == 1'b0, "R12", "reset wrCollision", int'(wrCollision), 0);
    rstN = 1'b1;
    autoClr = 1'b1;
    idle(4, "R12");

    // Single buffering, start-of-stop timing, extra request ignored (R2 R3 R9 R1)
    setCfg(0, 1, 0);
    irqSeen = 0;
    for (int k = 0; k < 3; k++) begin
      step(1, 8'hA5 ^ 8'(k), 0, "R2 R3 R9");
      if (k == 0) begin
        step(0, 8'h00, 0, "R10");
        step(1, 8'hFF, 0, "R10");
        step(0, 8'h00, 0, "R10");
        chk(lastCol == 1'b1, "R10", "collision flag", int'(lastCol), 1);
        idle(3, "R10");
        chk(lastCol == 1'b1, "R10", "collision sticky", int'(lastCol), 1);
        step(0, 8'h00, 1, "R10");
        step(0, 8'h00, 0, "R10");
        step(0, 8'h00, 0, "R10");
        chk(lastCol == 1'b0, "R10", "collision cleared", int'(lastCol), 0);
      end
      idle(56, "R1 R2 R3");
    end
    chk(irqSeen == 3, "R9", "single-mode irq count", irqSeen, 3);

    // Single buffering, end-of-stop timing (R4 R2)
    setCfg(0, 0, 1);
    irqSeen = 0;
    for (int k = 0; k < 3; k++) begin
      step(1, 8'h5A + 8'(k), 0, "R4 R2");
      idle(60, "R4 R2");
    end
    chk(irqSeen == 3, "R2", "single-mode end irq count", irqSeen, 3);

    // Two-stage buffering scenarios (R5 R6 R7 R8 R3 R4)
    dblRun(0, 0, 3, "R7 R6 R3");
    dblRun(1, 0, 4, "R8 R6 R3");
    dblRun(1, 1, 4, "R8 R4");
    dblRun(0, 1, 3, "R7 R4");

    // Random traffic with random clears and config changes (R11 R1 R6 R10)
    autoClr = 1'b0;
    for (int blk = 0; blk < 10; blk++) begin
      setCfg(1'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 400; i++)
        step(($urandom % 12 == 0), 8'($urandom), ($urandom % 16 == 0), "R11 R1 R6 R10");
    end
    idle(80, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule